// File: doc/BRIEF.md
# Multi-channel FIFO-to-memory DMA router

This block empties one shared input FIFO into separate memory buffers, one buffer per channel. Up to eight receive channels push words into the FIFO. Each word carries its channel number, a format flag that tells serial-audio words apart from packed 32-bit words, and 32 data bits. The engine takes words from the head of the FIFO and writes each one through a plain memory write port (address, data, write strobe) into the buffer of the channel it is tagged for. For audio words the three low data bits hold the channel number, so the engine clears them before the write. For packed words those bits are data and are written unchanged.

Software programs each channel with a base address, a signed step and a word count, then sets the channel's enable together with a global enable. Each channel has a status bit that reports whether it is busy. When a channel's last word has been written, it sets its bit in an interrupt latch. The latch can be read through a main port, which clears it, or through a shadow port, which leaves it unchanged.

Top module: `fifo_route_dma`

## Requirements
- R1: A word offered on `in_valid` while `fifo_full` is high is not stored, and `in_drop` is high in that cycle. After the next pop, a newly offered word is accepted again.
- R2: At most one word leaves the FIFO per clock, and only in a cycle where `mem_ready` is high. While `mem_ready` is low, the FIFO contents and `fifo_full` stay as they are.
- R3: A word with tag `in_chan` = c is written to channel c's current address. That address starts at c's base address when the channel is armed, and moves by the signed step after each write, modulo 2^16.
- R4: For a word with `in_audio` = 1, bits [2:0] are written as 0 and every other bit, bit 3 included, is unchanged. For a word with `in_audio` = 0, all 32 bits are written unchanged.
- R5: `chan_status[c]` becomes 1 one cycle after `dma_en` and `chan_en[c]` are both high with a non-zero count. Either enable alone does not set it.
- R6: `chan_status[c]` returns to 0 in the cycle after the channel's last programmed word has been written, even though both enables stay high.
- R7: A channel that has had no configuration write since reset reports `chan_status[c]` = 1. After its first configuration write it reports 0 until it is armed.
- R8: `irq_rdata[c]` becomes 1 in the cycle after channel c's last write. A one-cycle `irq_rd` pulse clears every latched bit on the next cycle.
- R9: `irq_rdata` is the value returned by both the main read and the shadow read. An `irq_shadow_rd` pulse does not change the latch.
- R10: A word tagged for a channel that is disabled or finished is still popped, but no memory write happens, and `err_flag` goes high and stays high until reset.
- R11: Each rising edge of a channel's combined enable reloads its current address from the base and its remaining count from the programmed count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A receive channel offers a word |
| in_audio | input | 1 | 1 = serial-audio word whose low bits are the tag; 0 = packed word |
| in_chan | input | 3 | Channel tag of the offered word |
| in_data | input | 32 | Offered data word |
| in_drop | output | 1 | Offered word was rejected because the FIFO is full |
| fifo_full | output | 1 | FIFO has no free entry |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 3 | Channel that the configuration write targets |
| cfg_base | input | 16 | Buffer base address |
| cfg_mod | input | 16 | Signed address step |
| cfg_count | input | 8 | Number of words to transfer |
| dma_en | input | 1 | Global enable |
| chan_en | input | 8 | Per-channel enables |
| chan_status | output | 8 | Per-channel busy status |
| mem_ready | input | 1 | Memory accepts a write this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_data | output | 32 | Memory write data |
| irq_rd | input | 1 | Main latch read; clears the latch |
| irq_shadow_rd | input | 1 | Shadow latch read; no side effect |
| irq_rdata | output | 8 | Interrupt latch contents |
| err_flag | output | 1 | Sticky flag for a discarded word |

## Verification
The main sweep runs every channel in turn. Even channels get audio words and odd channels get packed words. The low bits of each word are filled with the tag and an alternating left/right bit, which shows whether the clearing was applied to the right format and whether bit 3 survived it. Steps of +1 to +4 and -1 to -4, with counts of two or three, show whether the address moves by the signed step and whether each channel stops after the correct word. A burst of six words into a four-entry FIFO that is not being drained shows which words were dropped and that space is reused after one pop. A word sent to a finished channel shows that the word is discarded and that the error flag stays set.

// File: rtl/dma_route_pkg.sv
package dma_route_pkg;

    localparam int NCH = 8;
    localparam int DW  = 32;
    localparam int AW  = 16;
    localparam int CW  = 8;
    localparam int CHW = $clog2(NCH);

    typedef struct packed {
        logic           audio;
        logic [CHW-1:0] chan;
        logic [DW-1:0]  data;
    } fifo_word_t;

    // Audio words carry the tag in their low bits; those bits are cleared.
    function automatic logic [DW-1:0] strip_tag(fifo_word_t w);
        logic [DW-1:0] r;
        r = w.data;
        if (w.audio) r[CHW-1:0] = '0;
        return r;
    endfunction

endpackage

// File: rtl/word_fifo.sv
module word_fifo
    import dma_route_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  fifo_word_t din,
    input  logic       pop,
    output fifo_word_t dout,
    output logic       empty,
    output logic       full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    fifo_word_t          store [DEPTH];
    logic [PW-1:0]       wr_ptr, rd_ptr;
    logic [CNTW-1:0]     fill;
    logic                do_push, do_pop;

    assign full    = (fill == CNTW'(DEPTH));
    assign empty   = (fill == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store[rd_ptr];

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) begin
                store[wr_ptr] <= din;
                wr_ptr        <= bump(wr_ptr);
            end
            if (do_pop) rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/dma_chan_ctx.sv
module dma_chan_ctx
    import dma_route_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_mod,
    input  logic [CW-1:0] cfg_count,
    input  logic          enable,
    input  logic          wr,
    output logic [AW-1:0] cur_addr,
    output logic          active,
    output logic          status,
    output logic          done
);
    logic [AW-1:0] base_q, mod_q;
    logic [CW-1:0] count_q, remain;
    logic          touched, en_q;

    assign done   = wr && active && (remain == CW'(1));
    assign status = !touched || active;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            mod_q    <= '0;
            count_q  <= '0;
            touched  <= 1'b0;
            en_q     <= 1'b0;
            cur_addr <= '0;
            remain   <= '0;
            active   <= 1'b0;
        end else begin
            en_q <= enable;
            if (cfg_we) begin
                base_q  <= cfg_base;
                mod_q   <= cfg_mod;
                count_q <= cfg_count;
                touched <= 1'b1;
            end
            if (enable && !en_q) begin
                cur_addr <= base_q;
                remain   <= count_q;
                active   <= (count_q != '0);
            end else if (!enable) begin
                active <= 1'b0;
            end else if (wr && active) begin
                cur_addr <= cur_addr + mod_q;
                remain   <= remain - 1'b1;
                if (remain == CW'(1)) active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank
    import dma_route_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] set,
    input  logic           clr,
    output logic [NCH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (clr ? '0 : q) | set;
    end
endmodule

// File: rtl/fifo_route_dma.sv
module fifo_route_dma
    import dma_route_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           in_audio,
    input  logic [CHW-1:0] in_chan,
    input  logic [DW-1:0]  in_data,
    output logic           in_drop,
    output logic           fifo_full,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_chan,
    input  logic [AW-1:0]  cfg_base,
    input  logic [AW-1:0]  cfg_mod,
    input  logic [CW-1:0]  cfg_count,
    input  logic           dma_en,
    input  logic [NCH-1:0] chan_en,
    output logic [NCH-1:0] chan_status,
    input  logic           mem_ready,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_data,
    input  logic           irq_rd,
    input  logic           irq_shadow_rd,
    output logic [NCH-1:0] irq_rdata,
    output logic           err_flag
);
    fifo_word_t     in_word, head;
    logic           fifo_empty, pop, wr_hit;
    logic [CHW-1:0] head_chan;
    logic [NCH-1:0] chan_active, chan_done;
    logic [AW-1:0]  cur_addr [NCH];

    assign in_word = '{audio: in_audio, chan: in_chan, data: in_data};
    assign in_drop = in_valid && fifo_full;

    word_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (in_valid),
        .din   (in_word),
        .pop   (pop),
        .dout  (head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    assign head_chan = head.chan;
    assign pop       = !fifo_empty && mem_ready;
    assign wr_hit    = pop && dma_en && chan_en[head_chan] && chan_active[head_chan];

    assign mem_we   = wr_hit;
    assign mem_addr = cur_addr[head_chan];
    assign mem_data = strip_tag(head);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dma_chan_ctx u_ctx (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (cfg_we && (cfg_chan == CHW'(c))),
            .cfg_base  (cfg_base),
            .cfg_mod   (cfg_mod),
            .cfg_count (cfg_count),
            .enable    (dma_en && chan_en[c]),
            .wr        (wr_hit && (head_chan == CHW'(c))),
            .cur_addr  (cur_addr[c]),
            .active    (chan_active[c]),
            .status    (chan_status[c]),
            .done      (chan_done[c])
        );
    end

    irq_latch_bank u_irq (
        .clk (clk),
        .rst (rst),
        .set (chan_done),
        .clr (irq_rd),
        .q   (irq_rdata)
    );

    // Shadow reads see the same latch and have no side effect.
    logic unused_shadow;
    assign unused_shadow = irq_shadow_rd;

    always_ff @(posedge clk) begin
        if (rst)                  err_flag <= 1'b0;
        else if (pop && !wr_hit)  err_flag <= 1'b1;
    end
endmodule

module fifo_route_dma_chk
    import dma_route_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           fifo_full,
    input logic           mem_ready,
    input logic           mem_we,
    input logic           err_flag,
    input logic           rd_main,
    input logic           rd_shadow,
    input logic [NCH-1:0] irq,
    input logic [NCH-1:0] status,
    input logic [CHW-1:0] head_chan
);
    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && !mem_ready) |=> fifo_full);

    // R10
    write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> status[head_chan]);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R8
    main_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rd_main |=> ((irq & $past(irq)) == '0));

    // R9
    shadow_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_shadow && !rd_main) |=> ((irq & $past(irq)) == $past(irq)));
endmodule

bind fifo_route_dma fifo_route_dma_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .fifo_full (fifo_full),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .err_flag  (err_flag),
    .rd_main   (irq_rd),
    .rd_shadow (irq_shadow_rd),
    .irq       (irq_rdata),
    .status    (chan_status),
    .head_chan (head_chan)
);

// File: tb/fifo_route_dma_tb.sv
module fifo_route_dma_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_audio = 1'b0;
    logic [2:0]  in_chan = '0;
    logic [31:0] in_data = '0;
    logic        in_drop, fifo_full;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_chan = '0;
    logic [15:0] cfg_base = '0, cfg_mod = '0;
    logic [7:0]  cfg_count = '0;
    logic        dma_en = 1'b0;
    logic [7:0]  chan_en = '0;
    logic [7:0]  chan_status;
    logic        mem_ready = 1'b0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_data;
    logic        irq_rd = 1'b0, irq_shadow_rd = 1'b0;
    logic [7:0]  irq_rdata;
    logic        err_flag;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    fifo_route_dma #(.DEPTH(4)) dut_i (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] base_of(int c);
        return 16'(c * 32);
    endfunction
    function automatic logic [15:0] mod_of(int c);
        return (c < 4) ? 16'(c + 1) : 16'(-(c - 3));
    endfunction
    function automatic int count_of(int c);
        return 2 + (c % 2);
    endfunction

    task automatic cfg_write(int c, logic [15:0] b, logic [15:0] m, logic [7:0] n);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = 3'(c); cfg_base = b; cfg_mod = m; cfg_count = n;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic send(int c, bit aud, logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_audio = aud; in_chan = 3'(c); in_data = d;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    initial begin
        #(4 * 20000);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R7 reset status", 32'(chan_status), 32'hFF);
        chk("R8 reset irq", 32'(irq_rdata), 0);
        chk("R10 reset err", 32'(err_flag), 0);
        chk("R1 reset full", 32'(fifo_full), 0);

        for (int c = 0; c < 8; c++)
            cfg_write(c, base_of(c), mod_of(c), 8'(count_of(c)));
        #1 chk("R7 configured idle", 32'(chan_status), 0);

        @(negedge clk); chan_en = 8'hFF;
        @(posedge clk); #1;
        chk("R5 channel enables alone", 32'(chan_status), 0);
        @(negedge clk); dma_en = 1'b1; mem_ready = 1'b1;
        @(posedge clk); #1;
        chk("R5 both enables", 32'(chan_status), 32'hFF);

        // Sweep every channel: even = audio words, odd = packed words.
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < count_of(c); k++) begin
                logic [31:0] d, e;
                bit aud;
                aud = (c % 2 == 0);
                d = {8'hA5, 8'(c), 8'(k * 17 + 3), 4'h9, 1'(k), 3'(c ^ 5)};
                e = aud ? (d & 32'hFFFF_FFF8) : d;
                send(c, aud, d);
                chk("R3 write strobe", 32'(mem_we), 1);
                chk("R3 address", 32'(mem_addr), 32'(16'(base_of(c) + 16'(k) * mod_of(c))));
                chk("R4 data format", mem_data, e);
            end
            @(posedge clk); #1;
            chk("R6 status clears", 32'(chan_status[c]), 0);
            chk("R8 irq set", 32'(irq_rdata[c]), 1);
        end
        chk("R6 all done enables high", 32'(chan_status), 0);

        @(negedge clk); irq_shadow_rd = 1'b1;
        @(posedge clk); #1 irq_shadow_rd = 1'b0;
        chk("R9 shadow read keeps latch", 32'(irq_rdata), 32'hFF);
        @(negedge clk); irq_rd = 1'b1;
        @(posedge clk); #1 irq_rd = 1'b0;
        chk("R8 main read clears", 32'(irq_rdata), 0);

        send(0, 1'b0, 32'h0000_1234);
        chk("R10 no write for finished channel", 32'(mem_we), 0);
        @(posedge clk); #1;
        chk("R10 err sticky", 32'(err_flag), 1);
        chk("R10 word popped", 32'(fifo_full), 0);

        // Overflow burst into channel 1 with the memory stalled.
        @(negedge clk); mem_ready = 1'b0;
        cfg_write(1, base_of(1), mod_of(1), 8'd5);
        @(negedge clk); chan_en[1] = 1'b0;
        @(negedge clk); chan_en[1] = 1'b1;
        @(posedge clk); #1;
        chk("R11 rearm status", 32'(chan_status[1]), 1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_audio = 1'b0; in_chan = 3'd1; in_data = 32'hD0 + 32'(i);
            #1 chk("R1 drop when full", 32'(in_drop), (i >= 4) ? 1 : 0);
            @(posedge clk); #1 in_valid = 1'b0;
        end
        chk("R2 full while stalled", 32'(fifo_full), 1);
        @(negedge clk); mem_ready = 1'b1;
        #1 chk("R11 reloaded base", 32'(mem_addr), 32'(base_of(1)));
        chk("R1 first kept word", mem_data, 32'hD0);
        @(posedge clk); #1 mem_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_chan = 3'd1; in_data = 32'hD6;
        #1 chk("R1 accepted after pop", 32'(in_drop), 0);
        @(posedge clk); #1 in_valid = 1'b0;
        for (int j = 0; j < 4; j++) begin
            logic [31:0] ex;
            ex = (j == 3) ? 32'hD6 : 32'hD1 + 32'(j);
            @(negedge clk); mem_ready = 1'b1;
            #1;
            chk("R2 drain strobe", 32'(mem_we), 1);
            chk("R1 drained data", mem_data, ex);
            chk("R3 drained address", 32'(mem_addr),
                32'(16'(base_of(1) + 16'(j + 1) * mod_of(1))));
            @(posedge clk);
        end
        #1;
        chk("R6 rearmed channel done", 32'(chan_status[1]), 0);
        chk("R8 rearmed irq", 32'(irq_rdata), 32'h02);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule